// File: doc/BRIEF.md
# Coarse Delay-Line Edge Encoder with Fine-Tap Selection

This block takes the 32-bit word captured when a chain of delayed reference-clock copies samples the output clock of a digital PLL. The word is a pseudo-thermometer code. It can hold a falling (1 to 0) transition and a rising (0 to 1) transition. Before searching, the block removes single-bit bubbles with a three-input majority filter. It then finds the first falling transition and the first rising transition above it. From these two positions it reports three values: the coarse phase, the output-clock period in delay stages, and the select code for the external 32:1 multiplexer that routes a delayed reference tap to the fine converter.

The encoder takes time to resolve, and the reference edge keeps moving along the chain during that time. For this reason the select code points two stages past the last stage that held a 1, not one stage past it. Each stage is nominally 40 ps, so one count of the coarse and period outputs equals about 40 ps. Every output is registered, and each result appears exactly one clock after the sample that produced it.

Top module: `pt_edge_encoder`

## Requirements
- R1: `valid_o` is high in the clock cycle that follows a cycle with `valid_i` high, and low in the cycle that follows a cycle with `valid_i` low. All outputs are zero after reset.
- R2: Before the search, every bit i from 1 to 30 is replaced by the majority of input bits i-1, i and i+1. Bits 0 and 31 pass through unchanged. A lone flipped bit between two equal neighbours therefore has no effect on any output.
- R3: `coarse_o` is the lowest index i (0..30) whose filtered bit i is 1 and filtered bit i+1 is 0.
- R4: `period_o` equals 2*(j-i). Here j is the lowest index greater than i whose filtered bit j is 0 and filtered bit j+1 is 1.
- R5: If a falling transition exists but no rising transition exists above it, `no_rise_o` is 1 and `period_o` keeps its previous value. Otherwise `no_rise_o` is 0.
- R6: `sel_o` equals `coarse_o` + 2 when that sum is at most 31, and `tap_ovf_o` is then 0.
- R7: When `coarse_o` + 2 exceeds 31 (coarse index 30), `sel_o` saturates at 31 and `tap_ovf_o` is 1.
- R8: If the filtered word has no falling transition, `no_edge_o` is 1. In that case `coarse_o`, `sel_o`, `period_o`, `tap_ovf_o` and `no_rise_o` keep their previous values.
- R9: A cycle with `valid_i` low leaves `coarse_o`, `sel_o`, `period_o` and all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample word is valid |
| sample_i | input | 32 | Captured pseudo-thermometer word, bit 0 = least delayed copy |
| valid_o | output | 1 | Results updated from the previous valid sample |
| coarse_o | output | 5 | Index of the last 1 before the first falling transition |
| period_o | output | 6 | Output-clock period estimate in delay stages |
| sel_o | output | 5 | Tap select for the fine-path multiplexer |
| no_edge_o | output | 1 | No falling transition in the last valid sample |
| no_rise_o | output | 1 | No rising transition above the falling one |
| tap_ovf_o | output | 1 | Tap select saturated at the top of the chain |

## Verification
The assertions assume that `valid_i` and `sample_i` only change away from the rising clock edge. They also assume that the reset is released while `valid_i` is low, so the hold properties always compare against a value that was really loaded. The bench drives every input at the falling edge and holds `valid_i` low during and just after reset. Its stimulus includes clean edges at every position, stray single bits, words with no transition, words with no rising transition, and random words. Sweeping the falling edge all the way to index 30 reaches the saturation case.

// File: rtl/pt_enc_pkg.sv
package pt_enc_pkg;
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/pt_bubble_filter.sv
module pt_bubble_filter #(
  parameter int unsigned TAPS = 32
) (
  input  logic [TAPS-1:0] raw_i,
  output logic [TAPS-1:0] clean_o
);
  import pt_enc_pkg::*;

  assign clean_o[0]      = raw_i[0];
  assign clean_o[TAPS-1] = raw_i[TAPS-1];

  for (genvar g = 1; g < TAPS-1; g++) begin : g_maj
    assign clean_o[g] = maj3(raw_i[g-1], raw_i[g], raw_i[g+1]);
  end
endmodule

// File: rtl/pt_edge_find.sv
module pt_edge_find #(
  parameter int unsigned TAPS  = 32,
  parameter int unsigned IDX_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  vec_i,
  output logic             fall_hit_o,
  output logic [IDX_W-1:0] fall_idx_o,
  output logic             rise_hit_o,
  output logic [IDX_W:0]   period_o
);
  logic [IDX_W-1:0] rise_idx;
  logic [IDX_W-1:0] span;

  always_comb begin
    fall_hit_o = 1'b0;
    fall_idx_o = '0;
    for (int i = 0; i < TAPS-1; i++) begin
      if (!fall_hit_o && vec_i[i] && !vec_i[i+1]) begin
        fall_hit_o = 1'b1;
        fall_idx_o = IDX_W'(i);
      end
    end
  end

  // rising edge only counts above the falling one
  always_comb begin
    rise_hit_o = 1'b0;
    rise_idx   = '0;
    for (int i = 0; i < TAPS-1; i++) begin
      if (fall_hit_o && !rise_hit_o && (i > int'(fall_idx_o)) &&
          !vec_i[i] && vec_i[i+1]) begin
        rise_hit_o = 1'b1;
        rise_idx   = IDX_W'(i);
      end
    end
  end

  assign span     = rise_idx - fall_idx_o;
  assign period_o = {span, 1'b0};
endmodule

// File: rtl/pt_tap_sel.sv
module pt_tap_sel #(
  parameter int unsigned TAPS   = 32,
  parameter int unsigned OFFSET = 2,
  parameter int unsigned IDX_W  = $clog2(TAPS)
) (
  input  logic [IDX_W-1:0] pos_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             ovf_o
);
  localparam int unsigned SUM_W = IDX_W + 1;
  localparam logic [SUM_W-1:0] LAST = SUM_W'(TAPS-1);

  logic [SUM_W-1:0] sum;

  assign sum   = {1'b0, pos_i} + SUM_W'(OFFSET);
  assign ovf_o = sum > LAST;
  assign sel_o = ovf_o ? IDX_W'(TAPS-1) : sum[IDX_W-1:0];
endmodule

// File: rtl/pt_edge_encoder.sv
module pt_edge_encoder #(
  parameter int unsigned TAPS   = 32,
  parameter int unsigned OFFSET = 2,
  localparam int unsigned IDX_W = $clog2(TAPS),
  localparam int unsigned PER_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [TAPS-1:0]  sample_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] coarse_o,
  output logic [PER_W-1:0] period_o,
  output logic [IDX_W-1:0] sel_o,
  output logic             no_edge_o,
  output logic             no_rise_o,
  output logic             tap_ovf_o
);
  logic [TAPS-1:0]  clean;
  logic             fall_hit, rise_hit, ovf_c;
  logic [IDX_W-1:0] fall_idx, sel_c;
  logic [PER_W-1:0] per_c;

  pt_bubble_filter #(.TAPS(TAPS)) u_filt (
    .raw_i   (sample_i),
    .clean_o (clean)
  );

  pt_edge_find #(.TAPS(TAPS), .IDX_W(IDX_W)) u_find (
    .vec_i      (clean),
    .fall_hit_o (fall_hit),
    .fall_idx_o (fall_idx),
    .rise_hit_o (rise_hit),
    .period_o   (per_c)
  );

  pt_tap_sel #(.TAPS(TAPS), .OFFSET(OFFSET), .IDX_W(IDX_W)) u_sel (
    .pos_i (fall_idx),
    .sel_o (sel_c),
    .ovf_o (ovf_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      coarse_o  <= '0;
      period_o  <= '0;
      sel_o     <= '0;
      no_edge_o <= 1'b0;
      no_rise_o <= 1'b0;
      tap_ovf_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        no_edge_o <= !fall_hit;
        if (fall_hit) begin
          coarse_o  <= fall_idx;
          sel_o     <= sel_c;
          tap_ovf_o <= ovf_c;
          no_rise_o <= !rise_hit;
          if (rise_hit) period_o <= per_c;
        end
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R7
  ovf_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_ovf_o |-> (sel_o == IDX_W'(TAPS-1)));
  // R8
  noedge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_edge_o) |-> ($stable(coarse_o) && $stable(sel_o) && $stable(period_o)));
  // R5
  norise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && no_rise_o && !no_edge_o) |-> $stable(period_o));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(coarse_o) && $stable(sel_o) && $stable(period_o) && $stable(tap_ovf_o)));
endmodule

// File: tb/pt_edge_encoder_tb.sv
module pt_edge_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [31:0] sample = '0;
  logic        valid_out, no_edge, no_rise, tap_ovf;
  logic [4:0]  coarse, sel;
  logic [5:0]  period;

  int n_checks = 0;
  int n_fail   = 0;

  int e_valid = 0, e_coarse = 0, e_sel = 0, e_ovf = 0, e_per = 0, e_norise = 0, e_noedge = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_edge_encoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_in), .sample_i(sample),
    .valid_o(valid_out), .coarse_o(coarse), .period_o(period), .sel_o(sel),
    .no_edge_o(no_edge), .no_rise_o(no_rise), .tap_ovf_o(tap_ovf)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural reference: filter, scan, saturate
  task automatic model(input logic v, input logic [31:0] s);
    int f[32];
    int fi, rj;
    e_valid = v;
    if (!v) return;
    for (int i = 0; i < N; i++) begin
      if (i == 0 || i == N-1) f[i] = s[i];
      else f[i] = (int'(s[i-1]) + int'(s[i]) + int'(s[i+1])) >= 2;
    end
    fi = -1;
    for (int i = 0; i < N-1; i++)
      if (fi < 0 && f[i] == 1 && f[i+1] == 0) fi = i;
    e_noedge = (fi < 0);
    if (fi < 0) return;
    rj = -1;
    for (int j = fi+1; j < N-1; j++)
      if (rj < 0 && f[j] == 0 && f[j+1] == 1) rj = j;
    e_coarse = fi;
    e_sel    = (fi + 2 > N-1) ? N-1 : fi + 2;
    e_ovf    = (fi + 2 > N-1);
    e_norise = (rj < 0);
    if (rj >= 0) e_per = 2 * (rj - fi);
  endtask

  task automatic compare_all();
    check("R1", "valid_o",   valid_out, e_valid);
    check("R3", "coarse_o",  coarse,    e_coarse);
    check("R6", "sel_o",     sel,       e_sel);
    check("R7", "tap_ovf_o", tap_ovf,   e_ovf);
    check("R4", "period_o",  period,    e_per);
    check("R5", "no_rise_o", no_rise,   e_norise);
    check("R8", "no_edge_o", no_edge,   e_noedge);
  endtask

  task automatic step(input logic v, input logic [31:0] s);
    valid_in = v;
    sample   = s;
    @(posedge clk);
    model(v, s);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [31:0] mk(input int k, input int h);
    logic [31:0] w = '1;
    for (int i = k+1; i <= k+h && i < N; i++) w[i] = 1'b0;
    return w;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_all();

    // R3 R6 R4: clean edge at every position
    for (int k = 0; k < N-1; k++) step(1'b1, mk(k, 6));
    // R7 saturation at top index
    step(1'b1, mk(30, 1));
    check("R7", "sel at 30", sel, 31);
    // R5 no rising transition above
    step(1'b1, mk(10, 6));
    step(1'b1, mk(12, 40));
    check("R5", "period held", period, 12);
    // R8 no falling transition: all ones, all zeros
    step(1'b1, mk(5, 4));
    step(1'b1, '1);
    step(1'b1, '0);
    check("R8", "coarse held", coarse, 5);
    // R2 bubbles: stray 0 in ones run, stray 1 in zeros run
    step(1'b1, mk(20, 8) & ~32'h0000_0100);
    check("R2", "bubble 0 ignored", coarse, 20);
    step(1'b1, mk(8, 10) | 32'h0000_2000);
    check("R2", "bubble 1 ignored", period, 20);
    // R9 idle cycles with changing data
    step(1'b0, mk(3, 3));
    step(1'b0, '0);
    check("R9", "coarse held idle", coarse, 8);
    // random words, with random idle cycles
    for (int r = 0; r < 300; r++) step(1'($urandom_range(0, 3) != 0), $urandom);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule